// File: doc/BRIEF.md
# Output port register with atomic bit set and clear

This block drives one 16-pin general-purpose output port from a 32-bit word-access register bus. Software can load the whole port through a readable and writable data register. It can also change selected pins through a write-only set/clear register, which needs no read-modify-write sequence. Each set/clear write carries two fields. The lower half holds the pins to drive high, and the upper half holds the pins to drive low. When one write asks to both set and clear the same pin, the set wins.

Each register update takes effect on the clock edge that accepts the write. The pin vector is the register itself. Read data is combinational: it shows the current register contents while a read is enabled, and it is zero otherwise. The bus decodes the full address, and any offset other than the two register offsets is inert.

Top module: `pin_out_port`

## Requirements
- R1: While rst_ni is low, the data register and pins_o are all zero.
- R2: A write (wr_en_i high at a rising edge) to offset 0x0C loads wdata_i[15:0] into the data register, and pins_o shows the new value from that edge on.
- R3: A read (rd_en_i high) of offset 0x0C returns the data register in rdata_o[15:0]. rdata_o[31:16] reads as zero, and wdata_i[31:16] of a data write has no effect.
- R4: In a write to offset 0x10, each bit n of wdata_i[15:0] that is 1 drives output bit n high.
- R5: In a write to offset 0x10, each bit n+16 of wdata_i[31:16] that is 1 drives output bit n low.
- R6: When a write to offset 0x10 has both bit n and bit n+16 at 1, output bit n ends high.
- R7: In a write to offset 0x10, an output bit whose bit n and bit n+16 are both 0 keeps its earlier value.
- R8: A read of offset 0x10 returns zero.
- R9: A write to any offset other than 0x0C and 0x10 leaves the outputs unchanged, and a read of such an offset returns zero.
- R10: rdata_o is zero whenever rd_en_i is low. Without a write to 0x0C or 0x10, pins_o holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, combinational |
| pins_o | output | 16 | Output pin levels |

## Verification
The assertions are checked on every cycle. They confirm that set-requested pins end high and that clear-only pins end low. They also confirm that pins named in neither field keep their value, that a data write loads exactly its low half, and that outputs hold when no mapped write occurs. For read data, they confirm that the upper half is zero and that non-data offsets read zero. Some properties can only be shown by the bench scenarios. These are the reset state, the read-back of specific written values, and a set/clear conflict on each of the sixteen bits. They also include mixed set, clear and no-op patterns, and writes to unmapped or unaligned offsets. The bench shows them by comparing against a behavioural model on every clock.

// File: rtl/pin_out_pkg.sv
package pin_out_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned PORT_W = 16;
  localparam int unsigned OFF_W  = 8;

  typedef struct packed {
    logic data_we;
    logic sc_we;
    logic data_rd;
  } sel_t;
endpackage

// File: rtl/pin_out_decode.sv
module pin_out_decode
  import pin_out_pkg::*;
#(
  parameter int unsigned OFF_W_P  = OFF_W,
  parameter logic [OFF_W_P-1:0] DATA_OFF = 8'h0C,
  parameter logic [OFF_W_P-1:0] SC_OFF   = 8'h10
) (
  input  logic [OFF_W_P-1:0] addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output sel_t               sel_o
);
  logic hit_data, hit_sc;

  // full-address compare: unaligned and aliased offsets are unmapped
  assign hit_data = (addr_i == DATA_OFF);
  assign hit_sc   = (addr_i == SC_OFF);

  always_comb begin
    sel_o         = '0;
    sel_o.data_we = wr_en_i & hit_data;
    sel_o.sc_we   = wr_en_i & hit_sc;
    sel_o.data_rd = rd_en_i & hit_data;
  end
endmodule

// File: rtl/pin_out_merge.sv
module pin_out_merge
  import pin_out_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         load_en_i,
  input  logic         sc_en_i,
  output logic [W-1:0] nxt_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      nxt_o[b] = cur_i[b];
      if (load_en_i) begin
        nxt_o[b] = load_i[b];
      end else if (sc_en_i) begin
        // set checked last so it dominates clear
        if (clr_i[b]) nxt_o[b] = 1'b0;
        if (set_i[b]) nxt_o[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_out_reg.sv
module pin_out_reg
  import pin_out_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/pin_out_port.sv
module pin_out_port
  import pin_out_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned PW = PORT_W,
  parameter int unsigned AW = OFF_W,
  parameter logic [AW-1:0] DATA_OFF = 8'h0C,
  parameter logic [AW-1:0] SC_OFF   = 8'h10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic [PW-1:0] pins_o
);
  localparam int unsigned PAD_W = DW - PW;

  sel_t          sel;
  logic [PW-1:0] q, nxt;

  pin_out_decode #(
    .OFF_W_P (AW),
    .DATA_OFF(DATA_OFF),
    .SC_OFF  (SC_OFF)
  ) u_dec (
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .sel_o  (sel)
  );

  pin_out_merge #(.W(PW)) u_mrg (
    .cur_i    (q),
    .load_i   (wdata_i[PW-1:0]),
    .set_i    (wdata_i[PW-1:0]),
    .clr_i    (wdata_i[2*PW-1:PW]),
    .load_en_i(sel.data_we),
    .sc_en_i  (sel.sc_we),
    .nxt_o    (nxt)
  );

  pin_out_reg #(.W(PW)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sel.data_we | sel.sc_we),
    .d_i   (nxt),
    .q_o   (q)
  );

  assign pins_o  = q;
  assign rdata_o = sel.data_rd ? {{PAD_W{1'b0}}, q} : '0;
endmodule

// File: rtl/pin_out_port_chk.sv
module pin_out_port_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 16,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] DATA_OFF = 8'h0C,
  parameter logic [AW-1:0] SC_OFF   = 8'h10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [DW-1:0] wdata_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rdata_o,
  input logic [PW-1:0] pins_o
);
  logic sc_wr, d_wr;
  assign sc_wr = wr_en_i && (addr_i == SC_OFF);
  assign d_wr  = wr_en_i && (addr_i == DATA_OFF);

  a_r4_set_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_wr |=> ((pins_o & $past(wdata_i[PW-1:0])) == $past(wdata_i[PW-1:0])));

  a_r5_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_wr |=> ((pins_o & $past(wdata_i[2*PW-1:PW] & ~wdata_i[PW-1:0])) == '0));

  a_r7_untouched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_wr |=> (((pins_o ^ $past(pins_o)) &
                ~$past(wdata_i[2*PW-1:PW] | wdata_i[PW-1:0])) == '0));

  a_r2_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_wr |=> (pins_o == $past(wdata_i[PW-1:0])));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sc_wr || d_wr) |=> $stable(pins_o));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:PW] == '0);

  a_r9_unmapped_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || addr_i != DATA_OFF) |-> (rdata_o == '0));
endmodule

bind pin_out_port pin_out_port_chk #(
  .DW(DW), .PW(PW), .AW(AW), .DATA_OFF(DATA_OFF), .SC_OFF(SC_OFF)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .wdata_i(wdata_i),
  .rd_en_i(rd_en_i),
  .rdata_o(rdata_o),
  .pins_o (pins_o)
);

// File: tb/sim_pin_out_port.sv
`timescale 1ns/1ps
module sim_pin_out_port;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic [15:0] pins_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [15:0] model = '0;
  string       tag = "R1";

  pin_out_port u0 (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference, compared after every edge
  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      model = '0;
      tag = "R1";
    end else if (wr_en_i && addr_i == 8'h0C) begin
      model = wdata_i[15:0];
      tag = "R2";
    end else if (wr_en_i && addr_i == 8'h10) begin
      for (int b = 0; b < 16; b++) begin
        if (wdata_i[b]) model[b] = 1'b1;
        else if (wdata_i[b+16]) model[b] = 1'b0;
      end
      tag = "R4/R5/R6/R7";
    end else if (wr_en_i) begin
      tag = "R9";
    end else begin
      tag = "R10";
    end
    #1;
    chk(tag, {16'h0, pins_o}, {16'h0, model});
  end

  always @(posedge clk_i) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <=20000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1;
    chk(req, rdata_o, exp);
    rd_en_i = 1'b0;
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [7:0]  a;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", {16'h0, pins_o}, 32'h0);
    rd(8'h0C, 32'h0, "R1");
    @(negedge clk_i) rst_ni = 1'b1;

    // R2/R3 data load with upper half ignored
    wr(8'h0C, 32'hFFFF_A5C3);
    chk("R2", {16'h0, pins_o}, 32'h0000_A5C3);
    rd(8'h0C, 32'h0000_A5C3, "R3");
    wr(8'h0C, 32'h1234_0000);
    rd(8'h0C, 32'h0, "R3");

    // R4 set only, R7 others held
    wr(8'h0C, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0101);
    chk("R4", {16'h0, pins_o}, 32'h0000_01F1);
    // R5 clear only
    wr(8'h10, 32'h00F0_0000);
    chk("R5", {16'h0, pins_o}, 32'h0000_0101);
    // R6 all bits conflict
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R6", {16'h0, pins_o}, 32'h0000_FFFF);

    // R6 per-bit conflict from zero, R7 remaining bits untouched
    wr(8'h0C, 32'h0);
    for (int i = 0; i < 16; i++) begin
      wr(8'h10, (32'h1 << i) | (32'h1 << (i + 16)));
      chk("R6", {16'h0, pins_o}, (32'h1 << (i + 1)) - 1);
    end

    // mixed set/clear/no-op: (00FF & ~0F0F) | 3030 = 30F0
    wr(8'h0C, 32'h0000_00FF);
    wr(8'h10, 32'h0F0F_3030);
    chk("R7", {16'h0, pins_o}, 32'h0000_30F0);

    // R8 set/clear offset reads zero
    rd(8'h10, 32'h0, "R8");
    // R9 unmapped offsets
    wr(8'h14, 32'h0000_FFFF);
    wr(8'h0D, 32'h0000_0000);
    wr(8'h08, 32'hFFFF_0000);
    chk("R9", {16'h0, pins_o}, 32'h0000_30F0);
    rd(8'h14, 32'h0, "R9");
    rd(8'h0E, 32'h0, "R9");
    // R10 no read enable
    @(negedge clk_i) addr_i = 8'h0C;
    #1 chk("R10", rdata_o, 32'h0);

    // pseudo-random mix, model compared every clock
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: a = 8'h0C;
        2'd3: a = lfsr[9:2];
        default: a = 8'h10;
      endcase
      wr(a, {lfsr[15:0], lfsr[31:16]});
      rd(8'h0C, {16'h0, model}, "R3");
    end

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule